// File: doc/BRIEF.md
# Prioritized Interrupt Arbiter with Mask Levels and Held Level Requests

This block collects interrupt requests from a set of level-sensed external pins and a set of on-chip peripheral request lines, gives each source a programmable priority, and presents the single most urgent request to the processor. A request reaches the processor only when its level is strictly above both the processor's current mask level and a software-writable user mask level. A non-maskable request travels on its own output. It ignores both masks and can be held back only while the processor's block bit is set, and only if software has chosen that.

All priorities share one 5-bit level space. External pins take a 4-bit field, and the field value is doubled to give the level. Peripheral sources take a 5-bit field. When the processor accepts a maskable request, the block drives a write strobe and the accepted level so that the processor's mask register moves to that level. External pins can optionally be latched inside the block, so that a short pulse stays pending until software clears it.

Top module: `prio_intc`

## Requirements
- R1: An external pin's priority field (4 bits, pin i at bits 4i+3:4i of register 3) maps to level 2×field. A field of 0 disables the pin, so a forwarded request never has level 0.
- R2: A peripheral priority field (5 bits) is used as the level for values 1 to 30. A value of 31 is treated as level 30, and a value of 0 disables the source.
- R3: A source is eligible only if it is requesting and its level is strictly greater than both cpu_imask and the user mask (register 1, bits 4:0).
- R4: Among eligible sources the highest level wins, and ties go to the lowest source index. External pin i has index i. Peripheral j has index N_EXT+j.
- R5: irq_req, irq_level and irq_src are registered and reflect the inputs of the previous cycle. When no source is eligible, all three are 0.
- R6: When cpu_ack is 1 while irq_req is 1, imask_we is 1 in that same cycle and imask_new equals irq_level. Otherwise imask_we is 0.
- R7: irq_nmi follows nmi_pin one cycle later, independent of both masks. While cpu_bl is 1 it is suppressed, unless control bit 0 (NMI pass-through) is 1.
- R8: With control bit 1 (hold mode) set, an external pin that is high for one cycle is latched. Its request persists after the pin falls, and the latch shows in register 2 bit i.
- R9: With hold mode clear, external requests follow the pins and register 2 reads 0. Clearing hold mode empties every latch.
- R10: Writing 1 to bit i of register 2 clears latch i. A pin that is still high sets it again.
- R11: After reset all registers read 0 and no request is raised. Control bit 8 reads the live nmi_pin level.
- R12: Register map: address 0 is control, 1 is the user mask, 2 holds the pending latches, and 3 holds the external priorities. Address 4+k holds the peripheral fields 4k to 4k+3, with field j%4 at bits 8·(j%4)+4:8·(j%4). Written priority fields read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_pin | input | N_EXT | Level-sensed external request pins, active high |
| per_req | input | N_PER | Peripheral request lines, active high |
| nmi_pin | input | 1 | Non-maskable request pin, active high |
| cpu_imask | input | 5 | Processor's current mask level |
| cpu_bl | input | 1 | Processor block bit |
| cpu_ack | input | 1 | Processor accepts the presented maskable request |
| irq_req | output | 1 | Maskable request to the processor |
| irq_level | output | 5 | Level of the presented request |
| irq_src | output | SRC_W | Index of the presented source |
| irq_nmi | output | 1 | Non-maskable request to the processor |
| imask_we | output | 1 | Strobe to load the processor mask |
| imask_new | output | 5 | New processor mask level |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |

## Verification
A stored priority that is wrong, or a wrong level mapping, shows as the wrong irq_level or irq_src one cycle after the requests are applied. The bench sweeps request patterns against several mask levels so that every tie and every clamp shows up at the ports. A latch that is stuck or lost shows in the pending register in the next cycle. It also shows on irq_req one cycle after the pin falls, which is why pulses are checked after the pin has dropped. A wrong gate on the non-maskable path shows on irq_nmi one cycle after the pin or block bit changes.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;

  localparam int LVL_W   = 5;
  localparam int EXT_F_W = 4;
  localparam int PER_F_W = 5;
  localparam logic [LVL_W-1:0] PER_LVL_MAX = 5'd30;

  // External field is doubled into the shared level space.
  function automatic logic [LVL_W-1:0] ext_to_level(input logic [EXT_F_W-1:0] f);
    return {f, 1'b0};
  endfunction

  // Peripheral field saturates at the highest usable level.
  function automatic logic [LVL_W-1:0] per_to_level(input logic [PER_F_W-1:0] f);
    return (f > PER_LVL_MAX) ? PER_LVL_MAX : f;
  endfunction

  // Strictly above both masks; level 0 therefore never passes.
  function automatic logic clears_masks(input logic [LVL_W-1:0] lvl,
                                        input logic [LVL_W-1:0] cpu_m,
                                        input logic [LVL_W-1:0] usr_m);
    return (lvl > cpu_m) && (lvl > usr_m);
  endfunction

endpackage

// File: rtl/prio_intc_regs.sv
module prio_intc_regs
  import prio_intc_pkg::*;
#(
  parameter int N_EXT       = 4,
  parameter int N_PER       = 8,
  parameter int PER_PER_REG = 4,
  parameter int ADDR_W      = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic                 nmi_level,
  input  logic [N_EXT-1:0]     pend,
  output logic                 nmi_pass,
  output logic                 hold_en,
  output logic [LVL_W-1:0]     user_mask,
  output logic [N_EXT-1:0]     pend_clr,
  output logic [EXT_F_W-1:0]   ext_prio [N_EXT],
  output logic [PER_F_W-1:0]   per_prio [N_PER]
);

  localparam int A_CTRL  = 0;
  localparam int A_UMASK = 1;
  localparam int A_PEND  = 2;
  localparam int A_EXTP  = 3;
  localparam int A_PER0  = 4;
  localparam int LANE_W  = 32 / PER_PER_REG;

  logic wr_ctrl, wr_umask, wr_pend, wr_extp;

  assign wr_ctrl  = reg_wr && (int'(reg_addr) == A_CTRL);
  assign wr_umask = reg_wr && (int'(reg_addr) == A_UMASK);
  assign wr_pend  = reg_wr && (int'(reg_addr) == A_PEND);
  assign wr_extp  = reg_wr && (int'(reg_addr) == A_EXTP);

  assign pend_clr = wr_pend ? reg_wdata[N_EXT-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_pass  <= 1'b0;
      hold_en   <= 1'b0;
      user_mask <= '0;
    end else begin
      if (wr_ctrl) begin
        nmi_pass <= reg_wdata[0];
        hold_en  <= reg_wdata[1];
      end
      if (wr_umask) user_mask <= reg_wdata[LVL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_EXT; i++) ext_prio[i] <= '0;
    end else if (wr_extp) begin
      for (int i = 0; i < N_EXT; i++) ext_prio[i] <= reg_wdata[EXT_F_W*i +: EXT_F_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < N_PER; j++) per_prio[j] <= '0;
    end else if (reg_wr) begin
      for (int j = 0; j < N_PER; j++) begin
        if (int'(reg_addr) == A_PER0 + j / PER_PER_REG)
          per_prio[j] <= reg_wdata[LANE_W*(j % PER_PER_REG) +: PER_F_W];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (int'(reg_addr))
      A_CTRL:  reg_rdata = {23'b0, nmi_level, 6'b0, hold_en, nmi_pass};
      A_UMASK: reg_rdata[LVL_W-1:0] = user_mask;
      A_PEND:  reg_rdata[N_EXT-1:0] = pend;
      A_EXTP:  for (int i = 0; i < N_EXT; i++) reg_rdata[EXT_F_W*i +: EXT_F_W] = ext_prio[i];
      default: begin
        for (int j = 0; j < N_PER; j++) begin
          if (int'(reg_addr) == A_PER0 + j / PER_PER_REG)
            reg_rdata[LANE_W*(j % PER_PER_REG) +: PER_F_W] = per_prio[j];
        end
      end
    endcase
  end

endmodule

// File: rtl/prio_intc_hold.sv
module prio_intc_hold #(
  parameter int N_EXT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_en,
  input  logic [N_EXT-1:0] pin,
  input  logic [N_EXT-1:0] clr,
  output logic [N_EXT-1:0] latch_q,
  output logic [N_EXT-1:0] req
);

  for (genvar i = 0; i < N_EXT; i++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        latch_q[i] <= 1'b0;
      else if (!hold_en) latch_q[i] <= 1'b0;
      else               latch_q[i] <= (latch_q[i] & ~clr[i]) | pin[i];
    end

    assign req[i] = pin[i] | latch_q[i];

    AST_HOLD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_en && pin[i]) |=> latch_q[i]); // R8
  end

  AST_HOLD_OFF_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_en |=> (latch_q == '0)); // R9

endmodule

// File: rtl/prio_intc_arb.sv
module prio_intc_arb
  import prio_intc_pkg::*;
#(
  parameter int NSRC  = 12,
  parameter int SRC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_req,
  input  logic [LVL_W-1:0] src_lvl [NSRC],
  input  logic [LVL_W-1:0] cpu_imask,
  input  logic [LVL_W-1:0] user_mask,
  output logic             win_valid,
  output logic [LVL_W-1:0] win_level,
  output logic [SRC_W-1:0] win_idx
);

  logic [NSRC-1:0] eligible;

  for (genvar s = 0; s < NSRC; s++) begin : g_elig
    assign eligible[s] = src_req[s] && clears_masks(src_lvl[s], cpu_imask, user_mask);
  end

  // Linear scan: strict compare keeps the lowest index on a tie.
  always_comb begin
    win_valid = 1'b0;
    win_level = '0;
    win_idx   = '0;
    for (int s = 0; s < NSRC; s++) begin
      if (eligible[s] && (!win_valid || src_lvl[s] > win_level)) begin
        win_valid = 1'b1;
        win_level = src_lvl[s];
        win_idx   = SRC_W'(s);
      end
    end
  end

  AST_WIN_ABOVE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (win_level > cpu_imask && win_level > user_mask)); // R3

endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import prio_intc_pkg::*;
#(
  parameter int N_EXT       = 4,
  parameter int N_PER       = 8,
  parameter int PER_PER_REG = 4,
  parameter int NSRC        = N_EXT + N_PER,
  parameter int SRC_W       = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EXT-1:0] ext_pin,
  input  logic [N_PER-1:0] per_req,
  input  logic             nmi_pin,
  input  logic [4:0]       cpu_imask,
  input  logic             cpu_bl,
  input  logic             cpu_ack,
  output logic             irq_req,
  output logic [4:0]       irq_level,
  output logic [SRC_W-1:0] irq_src,
  output logic             irq_nmi,
  output logic             imask_we,
  output logic [4:0]       imask_new,
  input  logic             reg_wr,
  input  logic [3:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata
);

  logic                 nmi_pass, hold_en;
  logic [LVL_W-1:0]     user_mask;
  logic [N_EXT-1:0]     pend_clr, latch_q, ext_req;
  logic [EXT_F_W-1:0]   ext_prio [N_EXT];
  logic [PER_F_W-1:0]   per_prio [N_PER];
  logic [NSRC-1:0]      src_req;
  logic [LVL_W-1:0]     src_lvl [NSRC];
  logic                 win_valid;
  logic [LVL_W-1:0]     win_level;
  logic [SRC_W-1:0]     win_idx;
  logic                 nmi_gate_open;
  logic                 past_ok;

  prio_intc_regs #(
    .N_EXT(N_EXT), .N_PER(N_PER), .PER_PER_REG(PER_PER_REG), .ADDR_W(4)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .nmi_level(nmi_pin),
    .pend(latch_q), .nmi_pass(nmi_pass), .hold_en(hold_en),
    .user_mask(user_mask), .pend_clr(pend_clr),
    .ext_prio(ext_prio), .per_prio(per_prio)
  );

  prio_intc_hold #(.N_EXT(N_EXT)) u_hold (
    .clk(clk), .rst_n(rst_n), .hold_en(hold_en), .pin(ext_pin),
    .clr(pend_clr), .latch_q(latch_q), .req(ext_req)
  );

  for (genvar i = 0; i < N_EXT; i++) begin : g_ext_src
    assign src_req[i] = ext_req[i];
    assign src_lvl[i] = ext_to_level(ext_prio[i]);
  end

  for (genvar j = 0; j < N_PER; j++) begin : g_per_src
    assign src_req[N_EXT+j] = per_req[j];
    assign src_lvl[N_EXT+j] = per_to_level(per_prio[j]);
  end

  prio_intc_arb #(.NSRC(NSRC), .SRC_W(SRC_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_lvl(src_lvl),
    .cpu_imask(cpu_imask), .user_mask(user_mask),
    .win_valid(win_valid), .win_level(win_level), .win_idx(win_idx)
  );

  assign nmi_gate_open = !cpu_bl || nmi_pass;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_req   <= 1'b0;
      irq_level <= '0;
      irq_src   <= '0;
      irq_nmi   <= 1'b0;
      past_ok   <= 1'b0;
    end else begin
      irq_req   <= win_valid;
      irq_level <= win_level;
      irq_src   <= win_idx;
      irq_nmi   <= nmi_pin && nmi_gate_open;
      past_ok   <= 1'b1;
    end
  end

  assign imask_we  = cpu_ack && irq_req;
  assign imask_new = irq_level;

  AST_REQ_LEVEL_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_level != '0)); // R1

  AST_ACCEPT_RAISES_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    imask_we |-> (imask_new != '0)); // R6

  AST_NMI_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(nmi_pin) && !$past(cpu_bl)) |-> irq_nmi); // R7

  AST_NMI_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(nmi_pin)) |-> !irq_nmi); // R7

endmodule

// File: tb/prio_intc_tb.sv
module prio_intc_tb_top;

  localparam int N_EXT = 4;
  localparam int N_PER = 8;
  localparam int SRC_W = 4;
  localparam int NVEC  = 12;

  // {ext_pin, per_req, cpu_imask, exp_req, exp_level, exp_src}
  localparam logic [26:0] VEC [NVEC] = '{
    {4'b0001, 8'h00, 5'd0,  1'b1, 5'd6,  4'd0},
    {4'b0110, 8'h00, 5'd0,  1'b1, 5'd14, 4'd1},
    {4'b0100, 8'h02, 5'd0,  1'b1, 5'd14, 4'd2},
    {4'b0000, 8'h24, 5'd0,  1'b1, 5'd30, 4'd6},
    {4'b1000, 8'h08, 5'd0,  1'b0, 5'd0,  4'd0},
    {4'b0001, 8'h00, 5'd6,  1'b0, 5'd0,  4'd0},
    {4'b0001, 8'h00, 5'd5,  1'b1, 5'd6,  4'd0},
    {4'b0000, 8'hC0, 5'd0,  1'b1, 5'd9,  4'd11},
    {4'b0000, 8'h10, 5'd19, 1'b1, 5'd20, 4'd8},
    {4'b0000, 8'h10, 5'd20, 1'b0, 5'd0,  4'd0},
    {4'b1111, 8'hFF, 5'd31, 1'b0, 5'd0,  4'd0},
    {4'b1111, 8'hFF, 5'd0,  1'b1, 5'd30, 4'd6}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [N_EXT-1:0] ext_pin = '0;
  logic [N_PER-1:0] per_req = '0;
  logic             nmi_pin = 1'b0;
  logic [4:0]       cpu_imask = '0;
  logic             cpu_bl = 1'b0;
  logic             cpu_ack = 1'b0;
  logic             irq_req, irq_nmi, imask_we;
  logic [4:0]       irq_level, imask_new;
  logic [SRC_W-1:0] irq_src;
  logic             reg_wr = 1'b0;
  logic [3:0]       reg_addr = '0;
  logic [31:0]      reg_wdata = '0;
  logic [31:0]      reg_rdata;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  prio_intc #(.N_EXT(N_EXT), .N_PER(N_PER)) dut_i (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .per_req(per_req),
    .nmi_pin(nmi_pin), .cpu_imask(cpu_imask), .cpu_bl(cpu_bl),
    .cpu_ack(cpu_ack), .irq_req(irq_req), .irq_level(irq_level),
    .irq_src(irq_src), .irq_nmi(irq_nmi), .imask_we(imask_we),
    .imask_new(imask_new), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic irq_state(output logic [31:0] s);
    s = {22'b0, irq_req, irq_level, irq_src};
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] rd;
    logic [31:0] st;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: reset state
    rd_reg(4'd0, rd); check("R11", "ctrl after reset", rd, 32'h0);
    rd_reg(4'd3, rd); check("R11", "ext prio after reset", rd, 32'h0);
    irq_state(st);    check("R11", "irq after reset", {st[31:10], irq_nmi, st[9:0]}, 32'h0);

    // Program priorities: ext0=3, ext1=7, ext2=7, ext3=0; per 5,14,31,0,20,30,1,9
    wr_reg(4'd3, 32'h0000_0773);
    wr_reg(4'd4, 32'h001F_0E05);
    wr_reg(4'd5, 32'h0901_1E14);
    rd_reg(4'd3, rd); check("R12", "ext prio readback", rd, 32'h0000_0773);
    rd_reg(4'd5, rd); check("R12", "per prio reg 5 readback", rd, 32'h0901_1E14);

    // R1 R2 R3 R4 R5: vector table
    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      ext_pin   = VEC[v][26:23];
      per_req   = VEC[v][22:15];
      cpu_imask = VEC[v][14:10];
      @(negedge clk);
      irq_state(st);
      check("R4", $sformatf("vector %0d (R1 R2 R3 R5)", v), st, {22'b0, VEC[v][9:0]});
    end

    // R3: user mask
    @(negedge clk);
    ext_pin = '0; per_req = '0; cpu_imask = '0;
    wr_reg(4'd1, 32'd6);
    ext_pin = 4'b0001;
    @(negedge clk);
    irq_state(st); check("R3", "user mask 6 blocks level 6", st, 32'h0);
    ext_pin = 4'b0011;
    @(negedge clk);
    irq_state(st); check("R3", "user mask 6 passes level 14", st, {22'b0, 1'b1, 5'd14, 4'd1});
    wr_reg(4'd1, 32'd0);

    // R6: accept writes mask
    ext_pin = 4'b0010;
    @(negedge clk);
    cpu_ack = 1'b1;
    #1;
    check("R6", "imask_we on accept", {31'b0, imask_we}, 32'h1);
    check("R6", "imask_new on accept", {27'b0, imask_new}, 32'd14);
    @(negedge clk);
    cpu_ack = 1'b0;
    ext_pin = '0;
    repeat (2) @(negedge clk);
    cpu_ack = 1'b1;
    #1;
    check("R6", "no strobe without request", {31'b0, imask_we}, 32'h0);
    @(negedge clk);
    cpu_ack = 1'b0;

    // R7 R11: NMI path
    nmi_pin = 1'b1; cpu_imask = 5'd31;
    @(negedge clk);
    check("R7", "nmi passes masks", {31'b0, irq_nmi}, 32'h1);
    rd_reg(4'd0, rd); check("R11", "ctrl bit8 live nmi level", rd, 32'h100);
    cpu_bl = 1'b1;
    @(negedge clk);
    check("R7", "nmi blocked by bl", {31'b0, irq_nmi}, 32'h0);
    wr_reg(4'd0, 32'h1);
    @(negedge clk);
    check("R7", "nmi passes bl when enabled", {31'b0, irq_nmi}, 32'h1);
    nmi_pin = 1'b0; cpu_bl = 1'b0; cpu_imask = '0;
    @(negedge clk);
    check("R7", "nmi follows pin low", {31'b0, irq_nmi}, 32'h0);

    // R9: no hold, pulse is not kept
    ext_pin = 4'b0001;
    @(negedge clk);
    ext_pin = '0;
    @(negedge clk);
    irq_state(st); check("R9", "pulse dropped without hold", st, 32'h0);
    rd_reg(4'd2, rd); check("R9", "pending zero without hold", rd, 32'h0);

    // R8: hold mode latches pulse
    wr_reg(4'd0, 32'h2);
    ext_pin = 4'b0001;
    @(negedge clk);
    ext_pin = '0;
    @(negedge clk);
    irq_state(st); check("R8", "held request after pin drop", st, {22'b0, 1'b1, 5'd6, 4'd0});
    rd_reg(4'd2, rd); check("R8", "pending bit0", rd, 32'h1);

    // R10: write-one-to-clear
    wr_reg(4'd2, 32'h1);
    @(negedge clk);
    rd_reg(4'd2, rd); check("R10", "pending cleared", rd, 32'h0);
    irq_state(st);    check("R10", "request gone after clear", st, 32'h0);
    ext_pin = 4'b0010;
    @(negedge clk);
    wr_reg(4'd2, 32'h2);
    rd_reg(4'd2, rd); check("R10", "pin high re-sets latch", rd, 32'h2);
    ext_pin = '0;

    // R9: clearing hold empties latches
    wr_reg(4'd0, 32'h0);
    repeat (2) @(negedge clk);
    rd_reg(4'd2, rd); check("R9", "hold off empties latches", rd, 32'h0);
    irq_state(st);    check("R9", "no request after hold off", st, 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule